// File: doc/BRIEF.md
# Tag Store with Hit Comparator

This block keeps one tag word and three status bits for every line of a direct-mapped cache, and compares a presented tag with the stored one in the same cycle. The line index selects an entry. The stored tag, the stored status bits and the hit result are all combinational functions of the current inputs. New contents are taken on the rising clock edge. The tag field and the status field each have their own write strobe and their own output enable.

The three status bits can have one of two meanings. In internal mode they stand for valid, dirty and write-through, and the valid bit gates the hit output. In generic mode they are three plain user bits, and hit reports only whether the tags are equal. One clocked clear, active low, wipes the status bits of every entry in a single edge. This invalidates the whole cache at once.

There are two select inputs of opposite polarity and one sleep input. Together they decide whether the block responds. An output that would be high-impedance on a pad is modelled here as a data value of zero with its valid flag low.

Top module: `tag_store_cmp`

## Requirements
- R1: On a rising edge with the block selected, `clr_n` high and `tag_wr` high, `tag_in` is stored at `addr`. With `tag_oe` high and `tag_wr` low, `tag_out` shows the stored tag of `addr` and `tag_out_vld` is 1.
- R2: On a rising edge with the block selected, `clr_n` high and `stat_wr` high, `stat_in` is stored at `addr`. Bit 0 is valid, bit 1 is dirty and bit 2 is write-through. With `stat_oe` high and `stat_wr` low, `stat_out` shows the stored bits and `stat_out_vld` is 1.
- R3: While `stat_wr` is high and the block is selected, `stat_out` equals `stat_in` and `stat_out_vld` is 1, whatever the level of `stat_oe`.
- R4: A rising edge with `clr_n` low sets all three status bits of every entry to 0. This happens whether or not the block is selected. Stored tags are left unchanged.
- R5: With `generic_mode` at 0, `hit` is 1 only when the stored tag at `addr` equals `tag_in` in every bit and the stored valid bit is 1.
- R6: With `generic_mode` at 1, `hit` is 1 whenever the stored tag at `addr` equals `tag_in`, whatever the stored valid bit holds.
- R7: `hit` is 0 while any of the following holds: `tag_oe` is high, `tag_wr` is high, `stat_wr` is high, or `clr_n` is low.
- R8: The block is selected only when `sel_a_n` is 0, `sel_b` is 1 and `sleep` is 0. When it is not selected, every output flag and every data output is 0, and the tag and status write strobes change nothing.
- R9: While `clr_n` is low, `tag_out_vld` is 0. If the block is selected and `stat_oe` is high, `stat_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and the clear act on its rising edge |
| clr_n | input | 1 | Active-low clear of all status bits |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sleep | input | 1 | Power-down; blanks all outputs when high |
| generic_mode | input | 1 | 0: status bits are valid/dirty/write-through; 1: user bits |
| addr | input | ADDR_W | Line index |
| tag_in | input | TAG_W | Tag to store or to compare |
| tag_wr | input | 1 | Tag field write strobe |
| tag_oe | input | 1 | Tag output enable |
| stat_in | input | 3 | Status bits to store |
| stat_wr | input | 1 | Status field write strobe |
| stat_oe | input | 1 | Status output enable |
| tag_out | output | TAG_W | Stored tag read-out |
| tag_out_vld | output | 1 | Tag output is driven |
| stat_out | output | 3 | Status read-out or write-through value |
| stat_out_vld | output | 1 | Status output is driven |
| hit | output | 1 | Tag comparison result |
| hit_vld | output | 1 | Hit output is driven |

## Verification
The assertions rely on two input rules. First, no write strobe is raised in a cycle where `clr_n` is low. Second, `tag_wr` and `tag_oe` are never high together while the block is selected. Two assertions report any breach of these rules. The other assertions assume that inputs are stable around each rising edge. The stimulus changes every input only at the falling edge, and its read, write, clear and deselect patterns never combine those forbidden pairs. Deselected writes, sleep and clears that arrive while deselected are driven as legal patterns, and their results are then read back at the ports.

// File: rtl/tagstore_pkg.sv
package tagstore_pkg;
   // Status word of one line; bit 0 gates the hit in internal mode.
   typedef struct packed {
      logic wthru;
      logic dirty;
      logic valid;
   } stat_t;

   localparam int STAT_W = 3;
endpackage

// File: rtl/ts_tag_array.sv
module ts_tag_array #(
   parameter int ADDR_W = 8,
   parameter int TAG_W  = 12
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [TAG_W-1:0]  wr_data,
   output logic [TAG_W-1:0]  rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [TAG_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[addr] <= wr_data;
   end

   assign rd_data = mem[addr];

   AST_TAG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!clr_n)
      wr_en |=> (!$stable(addr) || rd_data == $past(wr_data))); // R1
endmodule

// File: rtl/ts_stat_array.sv
module ts_stat_array
   import tagstore_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  stat_t             wr_data,
   output stat_t             rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   stat_t ent [DEPTH];

   // One register per line so the clear reaches every line in one edge.
   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      stat_t q;
      logic  hit_line;
      assign hit_line = wr_en && (addr == ADDR_W'(i));
      always_ff @(posedge clk) begin
         if (!clr_n)        q <= '0;
         else if (hit_line) q <= wr_data;
      end
      assign ent[i] = q;
   end

   assign rd_data = ent[addr];

   AST_STAT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!clr_n)
      wr_en |=> (!$stable(addr) || rd_data == $past(wr_data))); // R2
   AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (!clr_n)
      $rose(clr_n) |-> rd_data == '0); // R4
endmodule

// File: rtl/ts_hit_unit.sv
module ts_hit_unit #(
   parameter int TAG_W     = 12,
   parameter int CMP_CHUNK = 4
) (
   input  logic [TAG_W-1:0] stored_tag,
   input  logic [TAG_W-1:0] probe_tag,
   input  logic             valid_bit,
   input  logic             generic_mode,
   input  logic             blocked,
   input  logic             selected,
   output logic             hit,
   output logic             hit_vld
);
   localparam int NCHUNK = (TAG_W + CMP_CHUNK - 1) / CMP_CHUNK;
   localparam int PAD_W  = NCHUNK * CMP_CHUNK;

   logic eq;

   if (NCHUNK == 1) begin : g_flat
      assign eq = (stored_tag == probe_tag);
   end else begin : g_split
      logic [PAD_W-1:0]  s_pad;
      logic [PAD_W-1:0]  p_pad;
      logic [NCHUNK-1:0] part_eq;
      assign s_pad = PAD_W'(stored_tag);
      assign p_pad = PAD_W'(probe_tag);
      for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
         assign part_eq[c] = (s_pad[c*CMP_CHUNK +: CMP_CHUNK] ==
                              p_pad[c*CMP_CHUNK +: CMP_CHUNK]);
      end
      assign eq = &part_eq;
   end

   logic qual;
   assign qual    = generic_mode | valid_bit;
   assign hit     = selected & ~blocked & eq & qual;
   assign hit_vld = selected;
endmodule

// File: rtl/tag_store_cmp.sv
module tag_store_cmp
   import tagstore_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int TAG_W     = 12,
   parameter int CMP_CHUNK = 4
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sleep,
   input  logic              generic_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [TAG_W-1:0]  tag_in,
   input  logic              tag_wr,
   input  logic              tag_oe,
   input  logic [2:0]        stat_in,
   input  logic              stat_wr,
   input  logic              stat_oe,
   output logic [TAG_W-1:0]  tag_out,
   output logic              tag_out_vld,
   output logic [2:0]        stat_out,
   output logic              stat_out_vld,
   output logic              hit,
   output logic              hit_vld
);
   if (ADDR_W < 1 || ADDR_W > 14) begin : g_bad_addr
      $error("tag_store_cmp: ADDR_W must lie in 1..14");
   end
   if (TAG_W < 1 || TAG_W > 64) begin : g_bad_tag
      $error("tag_store_cmp: TAG_W must lie in 1..64");
   end
   if (CMP_CHUNK < 1) begin : g_bad_chunk
      $error("tag_store_cmp: CMP_CHUNK must be positive");
   end

   logic             sel;
   logic             tag_we;
   logic             stat_we;
   logic [TAG_W-1:0] tag_rd;
   stat_t            stat_rd;
   stat_t            stat_wdat;
   logic             hit_block;

   assign sel       = !sel_a_n && sel_b && !sleep;
   assign tag_we    = sel && clr_n && tag_wr;
   assign stat_we   = sel && clr_n && stat_wr;
   assign stat_wdat = stat_t'(stat_in);
   assign hit_block = tag_oe || tag_wr || stat_wr || !clr_n;

   ts_tag_array #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .clr_n(clr_n), .wr_en(tag_we), .addr(addr),
      .wr_data(tag_in), .rd_data(tag_rd)
   );

   ts_stat_array #(.ADDR_W(ADDR_W)) u_stat (
      .clk(clk), .clr_n(clr_n), .wr_en(stat_we), .addr(addr),
      .wr_data(stat_wdat), .rd_data(stat_rd)
   );

   ts_hit_unit #(.TAG_W(TAG_W), .CMP_CHUNK(CMP_CHUNK)) u_hit (
      .stored_tag(tag_rd), .probe_tag(tag_in), .valid_bit(stat_rd.valid),
      .generic_mode(generic_mode), .blocked(hit_block), .selected(sel),
      .hit(hit), .hit_vld(hit_vld)
   );

   // Tag read-out: floats during a clear and when not enabled.
   always_comb begin
      tag_out_vld = sel && tag_oe && clr_n;
      tag_out     = tag_out_vld ? tag_rd : '0;
   end

   // Status read-out: write-through has priority, a clear reads as zero.
   always_comb begin
      stat_out_vld = sel && (stat_oe || stat_wr);
      if (!stat_out_vld) stat_out = '0;
      else if (stat_wr)  stat_out = stat_in;
      else if (!clr_n)   stat_out = '0;
      else               stat_out = stat_rd;
   end

   always @(posedge clk) begin
      if (!clr_n) begin
         AST_NO_WRITE_IN_CLEAR: assert (!(tag_wr || stat_wr))
            else $error("write strobe during clear"); // R4
      end
   end

   AST_NO_TAG_WR_WHILE_OE: assert property (@(posedge clk) disable iff (!clr_n)
      (sel && tag_wr) |-> !tag_oe); // R1
   AST_HIT_FORCED_LOW: assert property (@(posedge clk) disable iff (!clr_n)
      (tag_oe || tag_wr || stat_wr) |-> !hit); // R7
   AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!clr_n)
      (hit && !generic_mode) |-> stat_rd.valid); // R5
   AST_DESEL_KEEPS_TAG: assert property (@(posedge clk) disable iff (!clr_n)
      (!sel && tag_wr) |=> (!$stable(addr) || tag_rd == $past(tag_rd))); // R8
endmodule

// File: tb/tag_store_cmp_test.sv
module tag_store_cmp_test;
   localparam int AW = 4;
   localparam int TW = 12;
   localparam int N  = 1 << AW;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          clr_n = 1'b0, sel_a_n = 1'b0, sel_b = 1'b1, sleep = 1'b0;
   logic          generic_mode = 1'b0, tag_wr = 1'b0, tag_oe = 1'b0;
   logic          stat_wr = 1'b0, stat_oe = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [TW-1:0] tag_in = '0;
   logic [2:0]    stat_in = '0;
   logic [TW-1:0] tag_out;
   logic [2:0]    stat_out;
   logic          tag_out_vld, stat_out_vld, hit, hit_vld;

   tag_store_cmp #(.ADDR_W(AW), .TAG_W(TW), .CMP_CHUNK(5)) uut (
      .clk(clk), .clr_n(clr_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sleep(sleep),
      .generic_mode(generic_mode), .addr(addr), .tag_in(tag_in), .tag_wr(tag_wr),
      .tag_oe(tag_oe), .stat_in(stat_in), .stat_wr(stat_wr), .stat_oe(stat_oe),
      .tag_out(tag_out), .tag_out_vld(tag_out_vld), .stat_out(stat_out),
      .stat_out_vld(stat_out_vld), .hit(hit), .hit_vld(hit_vld)
   );

   typedef struct packed {
      logic [TW-1:0] t; logic tv; logic [2:0] s; logic sv; logic h; logic hv;
   } obs_t;

   obs_t  exp_q[$];
   string req_q[$];
   event  smp_ev;
   int    checks = 0, failures = 0;
   bit    done = 1'b0;

   logic [TW-1:0] m_tag [N];
   logic [2:0]    m_st  [N];

   function automatic logic [TW-1:0] tagv(int i);
      return TW'(i * 421) ^ 12'h5C3;
   endfunction

   // Monitor: pops the expected item and compares with the ports.
   initial begin
      obs_t e, a;
      string r;
      forever begin
         @(smp_ev);
         a = '{tag_out, tag_out_vld, stat_out, stat_out_vld, hit, hit_vld};
         checks++;
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL scoreboard: actual %h with no expected item", a);
         end else begin
            e = exp_q.pop_front();
            r = req_q.pop_front();
            if (a !== e) begin
               failures++;
               $display("FAIL %s: actual tag=%h/%b st=%b/%b hit=%b/%b expected tag=%h/%b st=%b/%b hit=%b/%b",
                        r, a.t, a.tv, a.s, a.sv, a.h, a.hv, e.t, e.tv, e.s, e.sv, e.h, e.hv);
            end
         end
      end
   end

   // Driver: applies one cycle of stimulus, predicts the outputs, updates the model.
   task automatic step(string req, logic sa_n, logic sb, logic slp, logic c, logic gm,
                       logic toe, logic soe, logic twr, logic swr,
                       logic [AW-1:0] a, logic [TW-1:0] ti, logic [2:0] si);
      obs_t e;
      logic s;
      @(negedge clk);
      sel_a_n = sa_n; sel_b = sb; sleep = slp; clr_n = c; generic_mode = gm;
      tag_oe = toe; stat_oe = soe; tag_wr = twr; stat_wr = swr;
      addr = a; tag_in = ti; stat_in = si;
      #2;
      s    = !sa_n && sb && !slp;
      e.tv = s && toe && c;
      e.t  = e.tv ? m_tag[a] : '0;
      e.sv = s && (soe || swr);
      e.s  = !e.sv ? 3'b000 : swr ? si : !c ? 3'b000 : m_st[a];
      e.hv = s;
      e.h  = s && c && !toe && !twr && !swr && (m_tag[a] == ti) && (gm || m_st[a][0]);
      exp_q.push_back(e);
      req_q.push_back(req);
      -> smp_ev;
      @(posedge clk);
      if (!c) begin
         for (int k = 0; k < N; k++) m_st[k] = 3'b000;
      end else if (s) begin
         if (twr) m_tag[a] = ti;
         if (swr) m_st[a]  = si;
      end
   endtask

   task automatic act(string req, logic gm, logic toe, logic soe, logic twr, logic swr,
                      logic [AW-1:0] a, logic [TW-1:0] ti, logic [2:0] si);
      step(req, 1'b0, 1'b1, 1'b0, 1'b1, gm, toe, soe, twr, swr, a, ti, si);
   endtask

   initial begin
      // R9: clear while selected with both output enables on
      step("R9", 0, 1, 0, 0, 0, 1, 1, 0, 0, 4'd3, '0, 3'b000);
      // R1: fill every tag
      for (int i = 0; i < N; i++) act("R1", 0, 0, 0, 1, 0, AW'(i), tagv(i), 3'b000);
      act("R1", 0, 1, 0, 0, 0, 4'd0,  '0, 3'b000);
      act("R1", 0, 1, 0, 0, 0, 4'd5,  '0, 3'b000);
      act("R1", 0, 1, 1, 0, 0, 4'd15, '0, 3'b000);
      // R4: status is zero after the clear
      act("R4", 0, 0, 1, 0, 0, 4'd7, '0, 3'b000);
      // R3: write-through with the status output enable off
      act("R3", 0, 0, 0, 0, 1, 4'd5, '0, 3'b001);
      act("R3", 0, 0, 0, 0, 1, 4'd6, '0, 3'b110);
      act("R2", 0, 0, 1, 0, 1, 4'd9, '0, 3'b101);
      act("R2", 0, 0, 1, 0, 0, 4'd6, '0, 3'b000);
      act("R2", 0, 0, 1, 0, 0, 4'd9, '0, 3'b000);
      // R5: internal mode hit qualification
      act("R5", 0, 0, 0, 0, 0, 4'd5, tagv(5), 3'b000);
      act("R5", 0, 0, 0, 0, 0, 4'd6, tagv(6), 3'b000);
      act("R5", 0, 0, 0, 0, 0, 4'd5, tagv(5) ^ 12'h001, 3'b000);
      act("R5", 0, 0, 0, 0, 0, 4'd5, tagv(5) ^ 12'h800, 3'b000);
      // R6: generic mode ignores the valid bit
      act("R6", 1, 0, 0, 0, 0, 4'd6, tagv(6), 3'b000);
      act("R6", 1, 0, 0, 0, 0, 4'd6, tagv(6) ^ 12'h040, 3'b000);
      // R7: hit forced low
      act("R7", 0, 1, 0, 0, 0, 4'd5, tagv(5), 3'b000);
      act("R7", 0, 0, 0, 1, 0, 4'd5, tagv(5), 3'b000);
      act("R7", 0, 0, 0, 0, 1, 4'd5, tagv(5), 3'b001);
      act("R7", 0, 0, 0, 0, 0, 4'd5, tagv(5), 3'b000);
      // R8: deselected and sleeping
      step("R8", 1, 1, 0, 1, 0, 0, 0, 1, 0, 4'd5, 12'h0FF, 3'b000);
      act("R8", 0, 1, 0, 0, 0, 4'd5, '0, 3'b000);
      step("R8", 0, 0, 0, 1, 0, 0, 0, 0, 1, 4'd9, '0, 3'b000);
      act("R8", 0, 0, 1, 0, 0, 4'd9, '0, 3'b000);
      step("R8", 0, 1, 1, 1, 0, 1, 1, 0, 0, 4'd9, tagv(9), 3'b000);
      // R4: clear while deselected wipes status, keeps tags
      step("R4", 1, 1, 0, 0, 0, 0, 1, 0, 0, 4'd9, '0, 3'b000);
      act("R4", 0, 0, 1, 0, 0, 4'd9, '0, 3'b000);
      act("R4", 0, 1, 0, 0, 0, 4'd9, '0, 3'b000);
      act("R4", 0, 0, 0, 0, 0, 4'd5, tagv(5), 3'b000);
      act("R6", 1, 0, 0, 0, 0, 4'd5, tagv(5), 3'b000);
      @(negedge clk);
      @(negedge clk);
      if (exp_q.size() != 0) begin
         failures++;
         $display("FAIL scoreboard: %0d expected items left, expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #4_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule